// File: doc/BRIEF.md
# Push-in priority list queue

This block is a small ordered store of cells held in registers. Each stored entry carries a cell tag and a rank. A requester inserts a new entry at any index it chooses. The entries already in the list keep their relative order, and only the neighbours behind the insertion point move one place toward the tail. Removal takes either the head entry (first-out mode) or the entry at any index (arbitrary-out mode). When removal is applied to a list kept in rank order, the departing cell is the one with the smallest rank.

One insert and one removal may be requested in the same cycle, and both are carried out. The removal is applied first, and the insertion index then refers to the shortened list. The block keeps its occupancy, the head entry, the removed entry and the error flags in registers. Every output therefore changes on the clock edge that follows the request.

Top module: `pifo_list`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `count` is 0, `empty` is 1, `full` is 0, and `overflow`, `underflow` and `rem_ok` are 0.
- R2: An accepted insert with `ins_pos` = X places the new entry so that exactly X entries are ahead of it. Entries from index X onward move one place toward the tail, and all stored entries keep their relative order.
- R3: An accepted insert whose `ins_pos` is greater than or equal to the current length appends the entry at the tail.
- R4: A removal with `rem_mode` = 0 (head) on a non-empty list takes the entry at index 0. After the next edge, `rem_ok` is 1 and `rem_tag`/`rem_rank` hold the removed entry, and the remaining entries advance one place.
- R5: A removal with `rem_mode` = 1 (indexed) and `rem_pos` below the length removes the entry at index `rem_pos`, where 0 is the head. It is reported as in R4, and the other entries keep their order.
- R6: An insert made while `count` = DEPTH, with no successful removal in the same cycle, is rejected. The contents stay unchanged and `overflow` is 1 for that single following cycle.
- R7: A removal request is rejected in two cases: on an empty list in head mode, or with an indexed `rem_pos` greater than or equal to the length. The contents stay unchanged, `rem_ok` is 0, and `underflow` is 1 for the following cycle.
- R8: When an insert and a removal arrive in the same cycle, the removal is applied first and `ins_pos` is taken relative to the list after removal. If the list was full, the insert is still accepted when the removal succeeds.
- R9: `count` gives the number of stored entries, `full` is 1 exactly when `count` = DEPTH, and `empty` is 1 exactly when `count` = 0. `head_tag`/`head_rank` show the entry at index 0 whenever the list is not empty.
- R10: A cycle with neither an insert nor a removal request leaves `count`, the head and the stored order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_pos | input | PW | Number of entries to leave ahead of the new entry |
| ins_tag | input | TW | Tag of the new entry |
| ins_rank | input | RW | Rank of the new entry |
| rem_valid | input | 1 | Removal request |
| rem_mode | input | 1 | 0 = remove head, 1 = remove at rem_pos |
| rem_pos | input | PW | Index to remove in indexed mode |
| rem_ok | output | 1 | Previous cycle's removal succeeded |
| rem_tag | output | TW | Tag of the last removed entry |
| rem_rank | output | RW | Rank of the last removed entry |
| head_tag | output | TW | Tag at index 0 |
| head_rank | output | RW | Rank at index 0 |
| count | output | PW | Occupancy |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| overflow | output | 1 | Previous cycle's insert was rejected |
| underflow | output | 1 | Previous cycle's removal was rejected |

PW = $clog2(DEPTH+1).

## Verification
The bench builds the block with DEPTH = 4, TW = 6 and RW = 5. The shallow list fills within a few cycles, so the random stream frequently hits rejected inserts, a combined removal and insert on a full list, and the last slot. With DEPTH = 4, PW is 3, so index values from 4 to 7 can be driven. These values exercise appending past the length on insert and out-of-range indexed removal. Directed sequences cover insertions at the head, in the middle and past the tail. Each sequence is then drained from the head to expose the stored order.

// File: rtl/pifo_pkg.sv
package pifo_pkg;
  typedef enum logic { RM_HEAD = 1'b0, RM_INDEX = 1'b1 } rm_mode_e;
endpackage

// File: rtl/pifo_ctrl.sv
module pifo_ctrl #(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          ins_valid,
  input  logic [PW-1:0] ins_pos,
  input  logic          rem_valid,
  input  logic          rem_mode,
  input  logic [PW-1:0] rem_pos,
  input  logic [PW-1:0] count,
  output logic          do_rem,
  output logic [PW-1:0] rem_idx,
  output logic          do_ins,
  output logic [PW-1:0] ins_idx,
  output logic [PW-1:0] cnt_nxt,
  output logic          ovf_nxt,
  output logic          unf_nxt
);
  import pifo_pkg::*;
  localparam logic [PW-1:0] DMAX = PW'(DEPTH);
  logic [PW-1:0] cnt_after;

  always_comb begin
    rem_idx   = (rm_mode_e'(rem_mode) == RM_INDEX) ? rem_pos : '0;
    do_rem    = rem_valid && (rem_idx < count);
    unf_nxt   = rem_valid && !do_rem;
    cnt_after = count - PW'(do_rem);
    do_ins    = ins_valid && (cnt_after < DMAX);
    ovf_nxt   = ins_valid && !do_ins;
    ins_idx   = (ins_pos > cnt_after) ? cnt_after : ins_pos;
    cnt_nxt   = cnt_after + PW'(do_ins);
  end
endmodule

// File: rtl/pifo_slot.sv
module pifo_slot #(
  parameter int IDX = 0,
  parameter int EW  = 8,
  parameter int PW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] prv,
  input  logic [EW-1:0] cur,
  input  logic [EW-1:0] nxt,
  input  logic [EW-1:0] new_e,
  input  logic          do_rem,
  input  logic [PW-1:0] rem_idx,
  input  logic          do_ins,
  input  logic [PW-1:0] ins_idx,
  output logic [EW-1:0] q
);
  localparam logic [PW-1:0] ME    = PW'(IDX);
  localparam logic [PW-1:0] ME_M1 = PW'((IDX == 0) ? 0 : IDX - 1);
  logic [EW-1:0] t_cur, t_prv, d;

  always_comb begin
    // list after removal, seen at this index and the one before
    t_cur = (!do_rem || ME < rem_idx) ? cur : nxt;
    if (IDX == 0) t_prv = cur;
    else          t_prv = (!do_rem || ME_M1 < rem_idx) ? prv : cur;
    // then insertion
    if (!do_ins || ME < ins_idx) d = t_cur;
    else if (ME == ins_idx)      d = new_e;
    else                         d = t_prv;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/pifo_list.sv
module pifo_list #(
  parameter int DEPTH = 8,
  parameter int TW    = 8,
  parameter int RW    = 8,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins_valid,
  input  logic [PW-1:0] ins_pos,
  input  logic [TW-1:0] ins_tag,
  input  logic [RW-1:0] ins_rank,
  input  logic          rem_valid,
  input  logic          rem_mode,
  input  logic [PW-1:0] rem_pos,
  output logic          rem_ok,
  output logic [TW-1:0] rem_tag,
  output logic [RW-1:0] rem_rank,
  output logic [TW-1:0] head_tag,
  output logic [RW-1:0] head_rank,
  output logic [PW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic          underflow
);
  localparam int EW = TW + RW;
  localparam logic [PW-1:0] DMAX = PW'(DEPTH);

  logic [EW-1:0] slot_q [DEPTH];
  logic          do_rem, do_ins, ovf_nxt, unf_nxt;
  logic [PW-1:0] rem_idx, ins_idx, cnt_nxt;
  logic [EW-1:0] rem_e;

  pifo_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .ins_valid(ins_valid), .ins_pos(ins_pos), .rem_valid(rem_valid),
    .rem_mode(rem_mode), .rem_pos(rem_pos), .count(count),
    .do_rem(do_rem), .rem_idx(rem_idx), .do_ins(do_ins), .ins_idx(ins_idx),
    .cnt_nxt(cnt_nxt), .ovf_nxt(ovf_nxt), .unf_nxt(unf_nxt)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [EW-1:0] prv_e, nxt_e;
    if (i == 0) begin : g_first
      assign prv_e = '0;
    end else begin : g_mid
      assign prv_e = slot_q[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign nxt_e = '0;
    end else begin : g_inner
      assign nxt_e = slot_q[i+1];
    end
    pifo_slot #(.IDX(i), .EW(EW), .PW(PW)) u_slot (
      .clk(clk), .rst(rst), .prv(prv_e), .cur(slot_q[i]), .nxt(nxt_e),
      .new_e({ins_tag, ins_rank}), .do_rem(do_rem), .rem_idx(rem_idx),
      .do_ins(do_ins), .ins_idx(ins_idx), .q(slot_q[i])
    );
  end

  always_comb begin
    rem_e = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rem_idx == PW'(i)) rem_e = slot_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0; full <= 1'b0; empty <= 1'b1;
      overflow <= 1'b0; underflow <= 1'b0;
      rem_ok <= 1'b0; rem_tag <= '0; rem_rank <= '0;
    end else begin
      count     <= cnt_nxt;
      full      <= (cnt_nxt == DMAX);
      empty     <= (cnt_nxt == '0);
      overflow  <= ovf_nxt;
      underflow <= unf_nxt;
      rem_ok    <= do_rem;
      if (do_rem) {rem_tag, rem_rank} <= rem_e;
    end
  end

  assign {head_tag, head_rank} = slot_q[0];

  // R9: occupancy bounded by the depth
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    count <= DMAX);
  // R6: rejection only when the list was full
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(ins_valid) && $past(full)));
  // R7: underflow only for a removal request on an empty list or bad index
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    underflow |-> ($past(rem_valid) && ($past(rem_mode) || $past(empty))));
  // R4: head removal returns the former head
  assert_head_out_R4: assert property (@(posedge clk) disable iff (rst)
    (rem_valid && !rem_mode && !empty) |=>
      (rem_ok && rem_tag == $past(head_tag) && rem_rank == $past(head_rank)));
  // R10: idle cycle holds state
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!ins_valid && !rem_valid) |=>
      ($stable(count) && $stable(head_tag) && $stable(head_rank)));
endmodule

// File: tb/pifo_list_test.sv
module pifo_list_test;
  localparam int D  = 4;
  localparam int TW = 6;
  localparam int RW = 5;
  localparam int PW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 0, rem_valid = 0, rem_mode = 0;
  logic [PW-1:0] ins_pos = '0, rem_pos = '0;
  logic [TW-1:0] ins_tag = '0;
  logic [RW-1:0] ins_rank = '0;
  logic rem_ok, full, empty, overflow, underflow;
  logic [TW-1:0] rem_tag, head_tag;
  logic [RW-1:0] rem_rank, head_rank;
  logic [PW-1:0] count;

  always #4 clk = ~clk;

  pifo_list #(.DEPTH(D), .TW(TW), .RW(RW)) uut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_pos(ins_pos),
    .ins_tag(ins_tag), .ins_rank(ins_rank), .rem_valid(rem_valid),
    .rem_mode(rem_mode), .rem_pos(rem_pos), .rem_ok(rem_ok),
    .rem_tag(rem_tag), .rem_rank(rem_rank), .head_tag(head_tag),
    .head_rank(head_rank), .count(count), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow)
  );

  int nvec = 0, nbad = 0;
  int m_cnt = 0;
  int m_tag [D];
  int m_rank [D];
  int e_ok, e_ovf, e_unf, e_rt, e_rr;

  task automatic chk(string req, string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference list update following the requirements
  task automatic model(bit iv, int ip, int it, int ir, bit rv, bit rm, int rp);
    int idx, p;
    idx = rm ? rp : 0;
    e_ok = (rv && idx < m_cnt) ? 1 : 0;
    e_unf = (rv && !e_ok) ? 1 : 0;
    if (e_ok != 0) begin
      e_rt = m_tag[idx]; e_rr = m_rank[idx];
      for (int k = idx; k < m_cnt - 1; k++) begin
        m_tag[k] = m_tag[k+1]; m_rank[k] = m_rank[k+1];
      end
      m_cnt--;
    end
    e_ovf = (iv && m_cnt >= D) ? 1 : 0;
    if (iv && m_cnt < D) begin
      p = (ip > m_cnt) ? m_cnt : ip;
      for (int k = m_cnt; k > p; k--) begin
        m_tag[k] = m_tag[k-1]; m_rank[k] = m_rank[k-1];
      end
      m_tag[p] = it; m_rank[p] = ir;
      m_cnt++;
    end
  endtask

  task automatic step(string req, bit iv, int ip, int it, int ir,
                      bit rv, bit rm, int rp);
    @(negedge clk);
    ins_valid = iv; ins_pos = PW'(ip); ins_tag = TW'(it); ins_rank = RW'(ir);
    rem_valid = rv; rem_mode = rm; rem_pos = PW'(rp);
    model(iv, ip, it % (1 << TW), ir % (1 << RW), rv, rm, rp);
    @(posedge clk); #2;
    chk(req, "count", int'(count), m_cnt);
    chk("R9", "full", int'(full), (m_cnt == D) ? 1 : 0);
    chk("R9", "empty", int'(empty), (m_cnt == 0) ? 1 : 0);
    if (m_cnt > 0) begin
      chk(req, "head_tag", int'(head_tag), m_tag[0]);
      chk(req, "head_rank", int'(head_rank), m_rank[0]);
    end
    chk("R6", "overflow", int'(overflow), e_ovf);
    chk("R7", "underflow", int'(underflow), e_unf);
    chk(req, "rem_ok", int'(rem_ok), e_ok);
    if (e_ok != 0) begin
      chk(req, "rem_tag", int'(rem_tag), e_rt);
      chk(req, "rem_rank", int'(rem_rank), e_rr);
    end
  endtask

  task automatic drain(string req);
    while (m_cnt > 0) step(req, 0, 0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "count in reset", int'(count), 0);
    chk("R1", "empty in reset", int'(empty), 1);
    chk("R1", "rem_ok in reset", int'(rem_ok), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    chk("R1", "count after reset", int'(count), 0);
    chk("R1", "full after reset", int'(full), 0);
    chk("R1", "overflow after reset", int'(overflow), 0);
    chk("R1", "underflow after reset", int'(underflow), 0);

    // R7: removal from empty, both modes
    step("R7", 0, 0, 0, 0, 1, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 1, 2);
    // R3: appends past the length
    step("R3", 1, 7, 10, 1, 0, 0, 0);
    step("R3", 1, 5, 11, 2, 0, 0, 0);
    // R2: head and middle insertion
    step("R2", 1, 0, 12, 3, 0, 0, 0);
    step("R2", 1, 1, 13, 4, 0, 0, 0);
    // R6: full list rejects insert
    step("R6", 1, 0, 14, 5, 0, 0, 0);
    // R10: idle keeps state
    step("R10", 0, 0, 0, 0, 0, 0, 0);
    // R7: indexed removal beyond length on full list
    step("R7", 0, 0, 0, 0, 1, 1, 5);
    // R8: removal and insert together on full list
    step("R8", 1, 2, 15, 6, 1, 1, 1);
    step("R8", 1, 7, 16, 7, 1, 0, 0);
    // R5: indexed removal of the last entry and a middle one
    step("R5", 0, 0, 0, 0, 1, 1, 3);
    step("R5", 0, 0, 0, 0, 1, 1, 1);
    // R4: drain from the head reveals the order
    drain("R4");
    step("R7", 0, 0, 0, 0, 1, 0, 0);

    // random mixed traffic
    for (int n = 0; n < 3000; n++) begin
      bit iv, rv, rm;
      iv = ($urandom % 3) != 0;
      rv = ($urandom % 3) == 0;
      rm = $urandom % 2;
      step(rm ? "R5" : "R2", iv, int'($urandom % (1 << PW)),
           int'($urandom % (1 << TW)), int'($urandom % (1 << RW)),
           rv, rm, int'($urandom % (1 << PW)));
    end
    drain("R4");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule